// File: doc/BRIEF.md
# FP Register Block Transfer Sequencer

This block moves floating-point register contents between a 64-word register file and a 32-bit memory port, one word per cycle. One command describes the whole transfer. It can be a list transfer (load-multiple or store-multiple, which also covers stack push and pop) or a transfer of one register at an immediate offset from a base. The sequencer does four things for each command:

- It works out the start address from the base value and an 8-bit word-count immediate.
- It walks the register list.
- It splits each double-width register into two 32-bit beats.
- It reports the updated base value when writeback is requested.

A push is a decrement-before list store with writeback on the stack pointer. A pop is an increment-after list load with writeback. Illegal encodings are detected at command acceptance and rejected before any memory or register activity. The register file and the base register sit outside the block. The sequencer reads them and writes them through strobes.

Top module: `fpls_seq`

## Requirements
- R1: After reset, `cmdReady` is 1 and `memValid`, `wbEn`, `errUndef` and `errUnpred` are 0.
- R2: A list transfer issues exactly `cmdImm` beats for singles, and 2 × floor(`cmdImm`/2) beats for doubles. A one-register transfer issues 1 beat for a single and 2 beats for a double.
- R3: In increment-after list mode (`cmdPre`=0, `cmdUp`=1), the first beat address is `cmdBase`, and every accepted beat moves the address up by 4.
- R4: In decrement-before list mode (`cmdPre`=1, `cmdUp`=0), the first beat address is `cmdBase` − 4·`cmdImm`, and addresses then rise by 4 per beat.
- R5: A list command with `cmdWback`=1 pulses `wbEn` for one cycle, in the cycle after its last beat is accepted. `wbData` is `cmdBase` + 4·`cmdImm` when `cmdUp`=1 and `cmdBase` − 4·`cmdImm` otherwise. With `cmdWback`=0, `wbEn` stays low.
- R6: Register word mapping is as follows. Single register k is word k. Double register k occupies words 2k (low) and 2k+1 (high). The beats of a double go low word first. When `cmdBigEnd`=1 the two words swap, so the high word goes to the lower address.
- R7: A load writes `memRdData` into word `fpIdx` (through `fpWrEn`/`fpWrData`) in the same cycle the beat is accepted. A store drives `memWrData` from `fpRdData` and sets `memWrite`=1.
- R8: A list command is flagged unpredictable (`errUnpred`) in any of these cases:
  - the register count is 0;
  - first register + count > 32;
  - the command is a double transfer with count > 16;
  - `cmdWback`=1 while `cmdBaseIsPc`=1.
- R9: A list command is flagged undefined (`errUndef`) unless its mode is (P=0, U=1) or (P=1, U=0, W=1). Undefined takes priority over unpredictable, so only one flag is raised.
- R10: A rejected command pulses its error flag for exactly one cycle, in the cycle after acceptance. It issues no memory request, no register write and no writeback.
- R11: A one-register transfer uses address base + 4·`cmdImm` when `cmdUp`=1 and base − 4·`cmdImm` otherwise. When `cmdBaseIsPc`=1 the base is first rounded down to a multiple of 4. This transfer has no writeback and no error checks.
- R12: While `memValid`=1 and `memReady`=0, the request and its address are held unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmdValid | input | 1 | Command present |
| cmdReady | output | 1 | Sequencer idle, command accepted this cycle if valid |
| cmdLoad | input | 1 | 1 = load from memory, 0 = store |
| cmdMulti | input | 1 | 1 = list transfer, 0 = one register at an offset |
| cmdDouble | input | 1 | 1 = double-width registers |
| cmdPre | input | 1 | Pre-index bit (list mode select) |
| cmdUp | input | 1 | Add (1) or subtract (0) the offset |
| cmdWback | input | 1 | Write updated base back (list only) |
| cmdBaseIsPc | input | 1 | Base register is the program counter |
| cmdBigEnd | input | 1 | Swap the two words of each double |
| cmdFirst | input | 5 | First register index |
| cmdImm | input | 8 | Immediate, in words |
| cmdBase | input | 32 | Base register value |
| memValid | output | 1 | Memory beat request |
| memWrite | output | 1 | Beat is a write |
| memAddr | output | 32 | Beat byte address |
| memWrData | output | 32 | Write data |
| memReady | input | 1 | Beat accepted (read data valid with it) |
| memRdData | input | 32 | Read data |
| fpIdx | output | 6 | Register file word index for current beat |
| fpRdData | input | 32 | Register file read data at `fpIdx` |
| fpWrEn | output | 1 | Register file write strobe |
| fpWrData | output | 32 | Register file write data |
| wbEn | output | 1 | Base writeback strobe |
| wbData | output | 32 | Base writeback value |
| errUndef | output | 1 | Undefined-encoding pulse |
| errUnpred | output | 1 | Unpredictable-encoding pulse |

## Verification
The hardest cases to reach from the ports come from combining conditions. One is a double transfer whose list ends exactly at register 31 or one past it, while the big-endian swap is on and the memory stalls mid-pair. Another is a command that is both undefined and unpredictable. The stimulus sweeps every P/U/W combination against both base kinds, both data widths, both word orders and a set of first-register and immediate values that sit on the 16 and 32 limits. Memory readiness follows a fixed irregular pattern, so stalls land on both halves of double beats.

// File: rtl/fpls_pkg.sv
package fpls_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_RUN, ST_WB} seqState_t;

  // control -> datapath strobes
  typedef struct packed {
    logic capture;  // latch a legal command
    logic advance;  // current beat accepted
  } seqStrobe_t;
endpackage

// File: rtl/fpls_datapath.sv
module fpls_datapath
  import fpls_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int IMM_W  = 8,
  parameter int REG_W  = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  seqStrobe_t        st,
  input  logic              cmdLoad,
  input  logic              cmdMulti,
  input  logic              cmdDouble,
  input  logic              cmdPre,
  input  logic              cmdUp,
  input  logic              cmdWback,
  input  logic              cmdBaseIsPc,
  input  logic              cmdBigEnd,
  input  logic [REG_W-1:0]  cmdFirst,
  input  logic [IMM_W-1:0]  cmdImm,
  input  logic [ADDR_W-1:0] cmdBase,
  output logic              undefC,
  output logic              unpredC,
  output logic              lastBeat,
  output logic              memWrite,
  output logic [ADDR_W-1:0] memAddr,
  output logic [REG_W:0]    fpIdx,
  output logic [ADDR_W-1:0] wbData
);
  localparam int NUM_REGS = 1 << REG_W;
  localparam int OFF_W    = IMM_W + 2;
  localparam int SUM_W    = IMM_W + 1;

  logic [ADDR_W-1:0] offset, effBase, startAddr;
  logic [IMM_W-1:0]  regCount, beats;
  logic [SUM_W-1:0]  span;
  logic              modeLegal;

  assign offset    = {{(ADDR_W-OFF_W){1'b0}}, cmdImm, 2'b00};
  assign effBase   = (!cmdMulti && cmdBaseIsPc) ? {cmdBase[ADDR_W-1:2], 2'b00} : cmdBase;
  assign startAddr = (cmdMulti && cmdUp) ? effBase
                   : (cmdUp ? effBase + offset : effBase - offset);

  // list checks
  assign regCount  = cmdDouble ? (cmdImm >> 1) : cmdImm;
  assign span      = SUM_W'(cmdFirst) + SUM_W'(regCount);
  assign modeLegal = (!cmdPre && cmdUp) || (cmdPre && !cmdUp && cmdWback);
  assign undefC    = cmdMulti && !modeLegal;
  assign unpredC   = cmdMulti && ((regCount == '0) || (span > SUM_W'(NUM_REGS)) ||
                     (cmdDouble && (regCount > IMM_W'(NUM_REGS/2))) ||
                     (cmdBaseIsPc && cmdWback));

  assign beats = cmdMulti ? (cmdDouble ? {cmdImm[IMM_W-1:1], 1'b0} : cmdImm)
                          : (cmdDouble ? IMM_W'(2) : IMM_W'(1));

  logic [ADDR_W-1:0] addrR, wbR;
  logic [IMM_W-1:0]  beatIdx, totalBeats;
  logic [REG_W-1:0]  firstR, regSel;
  logic              dblR, bigEndR, loadR;

  always_ff @(posedge clk) begin
    if (rst) begin
      addrR <= '0; wbR <= '0; beatIdx <= '0; totalBeats <= '0;
      firstR <= '0; dblR <= 1'b0; bigEndR <= 1'b0; loadR <= 1'b0;
    end else if (st.capture) begin
      addrR      <= startAddr;
      wbR        <= cmdUp ? cmdBase + offset : cmdBase - offset;
      beatIdx    <= '0;
      totalBeats <= beats;
      firstR     <= cmdFirst;
      dblR       <= cmdDouble;
      bigEndR    <= cmdBigEnd;
      loadR      <= cmdLoad;
    end else if (st.advance) begin
      addrR   <= addrR + ADDR_W'(4);
      beatIdx <= beatIdx + 1'b1;
    end
  end

  assign regSel   = firstR + (dblR ? beatIdx[REG_W:1] : beatIdx[REG_W-1:0]);
  assign fpIdx    = dblR ? {regSel, beatIdx[0] ^ bigEndR} : {1'b0, regSel};
  assign lastBeat = (beatIdx == totalBeats - 1'b1);
  assign memAddr  = addrR;
  assign memWrite = !loadR;
  assign wbData   = wbR;

  // R3: each accepted beat moves the address by one word
  a_r3_addr_step: assert property (@(posedge clk) disable iff (rst)
    st.advance |=> memAddr == $past(memAddr) + ADDR_W'(4));
  // R12: address only moves on capture or acceptance
  a_r12_addr_hold: assert property (@(posedge clk) disable iff (rst)
    (!st.advance && !st.capture) |=> $stable(memAddr));
endmodule

// File: rtl/fpls_control.sv
module fpls_control
  import fpls_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       cmdValid,
  input  logic       cmdMulti,
  input  logic       cmdWback,
  input  logic       undefC,
  input  logic       unpredC,
  input  logic       lastBeat,
  input  logic       memReady,
  output seqStrobe_t st,
  output logic       cmdReady,
  output logic       memValid,
  output logic       wbEn,
  output logic       errUndef,
  output logic       errUnpred
);
  seqState_t state, stateNext;
  logic      wbPend, accept;

  assign cmdReady   = (state == ST_IDLE);
  assign memValid   = (state == ST_RUN);
  assign wbEn       = (state == ST_WB);
  assign accept     = cmdReady && cmdValid;
  assign st.capture = accept && !undefC && !unpredC;
  assign st.advance = memValid && memReady;

  always_comb begin
    stateNext = state;
    case (state)
      ST_IDLE: if (st.capture) stateNext = ST_RUN;
      ST_RUN:  if (st.advance && lastBeat) stateNext = wbPend ? ST_WB : ST_IDLE;
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= ST_IDLE; wbPend <= 1'b0; errUndef <= 1'b0; errUnpred <= 1'b0;
    end else begin
      state     <= stateNext;
      errUndef  <= accept && undefC;
      errUnpred <= accept && !undefC && unpredC;
      if (st.capture) wbPend <= cmdMulti && cmdWback;
    end
  end

  // R12: a stalled beat stays requested
  a_r12_stall_hold: assert property (@(posedge clk) disable iff (rst)
    (memValid && !memReady) |=> memValid);
  // R5: writeback strobe lasts one cycle and returns to idle
  a_r5_wb_pulse: assert property (@(posedge clk) disable iff (rst)
    wbEn |=> (!wbEn && cmdReady));
  // R10: a rejected command starts no activity
  a_r10_no_req_on_err: assert property (@(posedge clk) disable iff (rst)
    (accept && (undefC || unpredC)) |=> (!memValid && !wbEn && (errUndef || errUnpred)));
endmodule

// File: rtl/fpls_seq.sv
module fpls_seq
  import fpls_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int IMM_W  = 8,
  parameter int REG_W  = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmdValid,
  output logic              cmdReady,
  input  logic              cmdLoad,
  input  logic              cmdMulti,
  input  logic              cmdDouble,
  input  logic              cmdPre,
  input  logic              cmdUp,
  input  logic              cmdWback,
  input  logic              cmdBaseIsPc,
  input  logic              cmdBigEnd,
  input  logic [REG_W-1:0]  cmdFirst,
  input  logic [IMM_W-1:0]  cmdImm,
  input  logic [ADDR_W-1:0] cmdBase,
  output logic              memValid,
  output logic              memWrite,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memWrData,
  input  logic              memReady,
  input  logic [DATA_W-1:0] memRdData,
  output logic [REG_W:0]    fpIdx,
  input  logic [DATA_W-1:0] fpRdData,
  output logic              fpWrEn,
  output logic [DATA_W-1:0] fpWrData,
  output logic              wbEn,
  output logic [ADDR_W-1:0] wbData,
  output logic              errUndef,
  output logic              errUnpred
);
  seqStrobe_t st;
  logic undefC, unpredC, lastBeat;

  fpls_control u_ctl (
    .clk, .rst, .cmdValid, .cmdMulti, .cmdWback, .undefC, .unpredC, .lastBeat,
    .memReady, .st, .cmdReady, .memValid, .wbEn, .errUndef, .errUnpred
  );

  fpls_datapath #(.ADDR_W(ADDR_W), .IMM_W(IMM_W), .REG_W(REG_W)) u_dp (
    .clk, .rst, .st, .cmdLoad, .cmdMulti, .cmdDouble, .cmdPre, .cmdUp, .cmdWback,
    .cmdBaseIsPc, .cmdBigEnd, .cmdFirst, .cmdImm, .cmdBase, .undefC, .unpredC,
    .lastBeat, .memWrite, .memAddr, .fpIdx, .wbData
  );

  assign memWrData = fpRdData;
  assign fpWrData  = memRdData;
  assign fpWrEn    = memValid && memReady && !memWrite;
endmodule

// File: tb/fpls_seq_bench.sv
module fpls_seq_bench;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst, cmdValid, cmdReady, cmdLoad, cmdMulti, cmdDouble, cmdPre, cmdUp, cmdWback;
  logic cmdBaseIsPc, cmdBigEnd;
  logic [4:0]  cmdFirst;
  logic [7:0]  cmdImm;
  logic [31:0] cmdBase;
  logic memValid, memWrite, memReady, fpWrEn, wbEn, errUndef, errUnpred;
  logic [31:0] memAddr, memWrData, memRdData, fpRdData, fpWrData, wbData;
  logic [5:0]  fpIdx;

  logic [31:0] mem [256];
  logic [31:0] rf  [64];
  assign fpRdData = rf[fpIdx];

  int total = 0, bad = 0, seq = 0;

  fpls_seq u_fpls_seq (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic runCmd(input bit ld, input bit multi, input bit dbl, input bit p, input bit u,
                        input bit w, input bit pc, input bit be, input int first, input int imm,
                        input logic [31:0] base);
    int cnt, expBeats, beats, wbSeen, guard, expIdx;
    bit expUndef, expUnpred, prevStall;
    logic [31:0] start, expWb, prevAddr, b;
    string aTag;
    cnt       = dbl ? imm / 2 : imm;
    expUndef  = multi && !((!p && u) || (p && !u && w));
    expUnpred = multi && !expUndef &&
                (cnt == 0 || first + cnt > 32 || (dbl && cnt > 16) || (pc && w));
    b         = (!multi && pc) ? (base & ~32'd3) : base;
    start     = (multi && u) ? b : (u ? b + 32'(imm * 4) : b - 32'(imm * 4));
    expWb     = u ? base + 32'(imm * 4) : base - 32'(imm * 4);
    expBeats  = multi ? (dbl ? 2 * cnt : cnt) : (dbl ? 2 : 1);
    aTag      = !multi ? "R11 addr" : (u ? "R3 addr" : "R4 addr");

    @(negedge clk);
    cmdLoad = ld; cmdMulti = multi; cmdDouble = dbl; cmdPre = p; cmdUp = u; cmdWback = w;
    cmdBaseIsPc = pc; cmdBigEnd = be; cmdFirst = 5'(first); cmdImm = 8'(imm); cmdBase = base;
    cmdValid = 1'b1;
    @(negedge clk);
    cmdValid = 1'b0;
    chk("R9 undef flag", 32'(errUndef), 32'(expUndef));
    chk("R8 unpred flag", 32'(errUnpred), 32'(expUnpred));
    if (expUndef || expUnpred) begin
      chk("R10 no request", 32'(memValid), 0);
      @(negedge clk);
      chk("R10 single pulse", 32'(errUndef | errUnpred), 0);
      chk("R10 no wb/req", 32'({wbEn, memValid}), 0);
      return;
    end
    beats = 0; wbSeen = 0; guard = 0; prevStall = 0; prevAddr = '0;
    forever begin
      if (memValid) begin
        if (prevStall) chk("R12 held addr", memAddr, prevAddr);
        memReady  = ((seq * 7) % 5) != 0;
        seq++;
        memRdData = mem[memAddr[9:2]];
        #1;
        if (memReady) begin
          expIdx = dbl ? 2 * (first + beats / 2) + ((beats % 2) ^ int'(be)) : first + beats;
          chk(aTag, memAddr, start + 32'(beats * 4));
          chk("R6 word index", 32'(fpIdx), 32'(expIdx));
          chk("R7 direction", 32'(memWrite), 32'(!ld));
          if (ld) begin
            chk("R7 load strobe", 32'(fpWrEn), 1);
            chk("R7 load data", fpWrData, mem[memAddr[9:2]]);
            rf[expIdx] = mem[memAddr[9:2]];
          end else begin
            chk("R7 store data", memWrData, rf[expIdx]);
            mem[memAddr[9:2]] = rf[expIdx];
          end
          beats++;
        end
        prevStall = !memReady;
        prevAddr  = memAddr;
      end else begin
        memReady = 1'b0;
        prevStall = 0;
      end
      if (wbEn) begin
        wbSeen++;
        chk("R5 wb value", wbData, expWb);
      end
      if (cmdReady) break;
      guard++;
      if (guard > 600) begin
        chk("R2 hung command", 0, 1);
        break;
      end
      @(negedge clk);
    end
    memReady = 1'b0;
    chk("R2 beat count", 32'(beats), 32'(expBeats));
    chk(multi ? "R5 wb count" : "R11 no wb", 32'(wbSeen), 32'(multi && w));
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog act=running exp=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int firsts[7];
    int imms[10];
    firsts = '{0, 1, 7, 15, 16, 30, 31};
    imms   = '{0, 1, 2, 3, 4, 6, 16, 32, 33, 34};
    for (int i = 0; i < 256; i++) mem[i] = 32'(i) * 32'h9E3779B1 + 32'h1;
    for (int i = 0; i < 64; i++)  rf[i]  = 32'hC0DE0000 + 32'(i);
    rst = 1'b1; cmdValid = 0; cmdLoad = 0; cmdMulti = 0; cmdDouble = 0; cmdPre = 0;
    cmdUp = 0; cmdWback = 0; cmdBaseIsPc = 0; cmdBigEnd = 0; cmdFirst = '0; cmdImm = '0;
    cmdBase = '0; memReady = 0; memRdData = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 reset ready", 32'(cmdReady), 1);
    chk("R1 reset idle", 32'({memValid, wbEn, errUndef, errUnpred}), 0);

    // list transfers: every mode bit combination
    for (int ld = 0; ld < 2; ld++)
      for (int dbl = 0; dbl < 2; dbl++)
        for (int puw = 0; puw < 8; puw++)
          for (int pc = 0; pc < 2; pc++)
            for (int be = 0; be < 2; be++)
              for (int fi = 0; fi < 7; fi++)
                for (int ii = 0; ii < 10; ii++)
                  runCmd(ld[0], 1'b1, dbl[0], puw[2], puw[1], puw[0], pc[0], be[0],
                         firsts[fi], imms[ii], 32'h200);

    // one-register transfers
    for (int ld = 0; ld < 2; ld++)
      for (int dbl = 0; dbl < 2; dbl++)
        for (int u = 0; u < 2; u++)
          for (int pc = 0; pc < 2; pc++)
            for (int be = 0; be < 2; be++)
              for (int fi = 0; fi < 7; fi++)
                for (int ii = 0; ii < 10; ii++)
                  runCmd(ld[0], 1'b0, dbl[0], 1'b0, u[0], 1'b1, pc[0], be[0],
                         firsts[fi], imms[ii], pc ? 32'h202 : 32'h200);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule